// File: doc/BRIEF.md
# Recursive Halving Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. It does not build a flat array of partial products. Each operand is cut into an upper half and a lower half, and four half-width products are formed: upper by upper, upper by lower, lower by upper and lower by lower. Each of those is built by the same structure at half the width. The recursion ends at tiny leaf multipliers. A 1-bit leaf is a single AND gate, and a 2-bit leaf is a handful of gates. At every level a stitch stage aligns the four sub-products and adds them. The lower-by-lower product stays at bit 0, the two cross products move up by N/2 bits, and the upper-by-upper product moves up by N bits.

The datapath is combinational. A parameter can place a register on the product, and that register is cleared by an asynchronous active-low reset. When the register is left out, the clock and reset have no effect on the result.

Top module: `dcmul_top`

## Requirements
- R1: For every pair of N-bit unsigned operands, prod_o equals a_i multiplied by b_i as a 2N-bit unsigned value.
- R2: When either operand is zero, every bit of prod_o is zero.
- R3: When both operands are all ones, prod_o equals (2^N-1)^2. For N=8 that is 16'hFE01.
- R4: When one operand equals 1, prod_o equals the other operand with N zero bits above it.
- R5: When the upper N/2 bits of either operand are all zero, the top N/2 bits of prod_o are zero.
- R6: With OUT_REG=1, prod_o shows the product of the operands sampled at the previous rising clock edge. It holds that value until the next rising edge, whatever the inputs do in between. With OUT_REG=0, prod_o follows the inputs with no clock.
- R7: With OUT_REG=1, driving rst_ni low forces prod_o to zero at once, without waiting for a clock edge. prod_o stays zero for as long as rst_ni is low.
- R8: For N=8, the operands 185 and 39 give the product 7215.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional product register |
| rst_ni | input | 1 | Asynchronous active-low reset of the product register |
| a_i | input | N | First unsigned operand |
| b_i | input | N | Second unsigned operand |
| prod_o | output | 2N | Unsigned product |

## Verification
The hardest case to reach is a carry that starts in the lowest leaf and travels through every stitch adder into the top half of the product. The operands must sit in particular bands for that to happen: both near all ones, or cross products that fill the middle bits. The bench therefore sweeps all 65,536 operand pairs at N=8, so every stitch level sees each carry pattern. Each result is checked one cycle after it is driven, through the output register. Directed steps then check that the register ignores input changes between clock edges, and that the reset clears the output at once, in the middle of the run.

// File: rtl/dcmul_pkg.sv
package dcmul_pkg;
  // width at which recursion stops (1 or 2)
  localparam int unsigned DefLeafW = 2;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/dcmul_leaf.sv
module dcmul_leaf #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  if (W == 1) begin : g_and
    assign p_o = {1'b0, a_i[0] & b_i[0]};
  end else begin : g_two
    logic c_lo, c_hi;
    assign c_lo   = a_i[1] & b_i[0];
    assign c_hi   = a_i[0] & b_i[1];
    assign p_o[0] = a_i[0] & b_i[0];
    assign p_o[1] = c_lo ^ c_hi;
    assign p_o[2] = (a_i[1] & b_i[1]) ^ (c_lo & c_hi);
    assign p_o[3] = a_i[1] & b_i[1] & c_lo & c_hi;
  end
endmodule

// File: rtl/dcmul_stitch.sv
module dcmul_stitch #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0]   hh_i,
  input  logic [W-1:0]   hl_i,
  input  logic [W-1:0]   lh_i,
  input  logic [W-1:0]   ll_i,
  output logic [2*W-1:0] p_o
);
  localparam int unsigned H = W / 2;

  logic [W:0]     mid;
  logic [2*W-1:0] mid_al;

  // cross terms summed first, then one aligned add onto {hh,ll}
  assign mid    = {1'b0, hl_i} + {1'b0, lh_i};
  assign mid_al = {{(W-1){1'b0}}, mid} << H;
  assign p_o    = {hh_i, ll_i} + mid_al;
endmodule

// File: rtl/dcmul_core.sv
module dcmul_core #(
  parameter int unsigned W      = 8,
  parameter int unsigned LEAF_W = dcmul_pkg::DefLeafW
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int unsigned H = W / 2;

  if (W <= LEAF_W) begin : g_leaf
    dcmul_leaf #(.W(W)) i_leaf (.a_i(a_i), .b_i(b_i), .p_o(p_o));
  end else begin : g_split
    logic [W-1:0] p_hh, p_hl, p_lh, p_ll;

    dcmul_core #(.W(H), .LEAF_W(LEAF_W)) i_hh (
      .a_i(a_i[W-1:H]), .b_i(b_i[W-1:H]), .p_o(p_hh));
    dcmul_core #(.W(H), .LEAF_W(LEAF_W)) i_hl (
      .a_i(a_i[W-1:H]), .b_i(b_i[H-1:0]), .p_o(p_hl));
    dcmul_core #(.W(H), .LEAF_W(LEAF_W)) i_lh (
      .a_i(a_i[H-1:0]), .b_i(b_i[W-1:H]), .p_o(p_lh));
    dcmul_core #(.W(H), .LEAF_W(LEAF_W)) i_ll (
      .a_i(a_i[H-1:0]), .b_i(b_i[H-1:0]), .p_o(p_ll));

    dcmul_stitch #(.W(W)) i_stitch (
      .hh_i(p_hh), .hl_i(p_hl), .lh_i(p_lh), .ll_i(p_ll), .p_o(p_o));
  end
endmodule

// File: rtl/dcmul_top.sv
module dcmul_top #(
  parameter int unsigned N       = 8,
  parameter int unsigned LEAF_W  = dcmul_pkg::DefLeafW,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] prod_o
);
  localparam int unsigned PW = 2 * N;

  initial begin
    if (!dcmul_pkg::is_pow2(N) || N < 2) $error("N must be a power of two >= 2");
    if (LEAF_W != 1 && LEAF_W != 2) $error("LEAF_W must be 1 or 2");
  end

  logic [PW-1:0] prod_c;

  dcmul_core #(.W(N), .LEAF_W(LEAF_W)) i_core (
    .a_i(a_i), .b_i(b_i), .p_o(prod_c));

  if (OUT_REG) begin : g_reg
    logic [PW-1:0] prod_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prod_q <= '0;
      else         prod_q <= prod_c;
    end
    assign prod_o = prod_q;
  end else begin : g_comb
    assign prod_o = prod_c;
  end
endmodule

// File: rtl/dcmul_chk.sv
module dcmul_chk #(
  parameter int unsigned N       = 8,
  parameter bit          OUT_REG = 1'b1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [N-1:0]   a_i,
  input logic [N-1:0]   b_i,
  input logic [2*N-1:0] prod_o
);
  localparam int unsigned H = N / 2;

  logic [N-1:0]   a_d, b_d, src_a, src_b;
  logic           v_d, live;
  logic [2*N-1:0] want;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_d <= '0;
      b_d <= '0;
      v_d <= 1'b0;
    end else begin
      a_d <= a_i;
      b_d <= b_i;
      v_d <= 1'b1;
    end
  end

  assign src_a = OUT_REG ? a_d : a_i;
  assign src_b = OUT_REG ? b_d : b_i;
  assign live  = OUT_REG ? v_d : 1'b1;
  assign want  = {{N{1'b0}}, src_a} * {{N{1'b0}}, src_b};

  AST_PROD_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |-> prod_o == want) else $error("product mismatch"); // R1
  AST_ZERO_OPND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && (src_a == '0 || src_b == '0)) |-> prod_o == '0) else $error("zero operand"); // R2
  AST_UNIT_OPND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && src_a == N'(1)) |-> prod_o == {{N{1'b0}}, src_b}) else $error("unit operand"); // R4
  AST_HALF_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && (src_a[N-1:H] == '0 || src_b[N-1:H] == '0)) |-> prod_o[2*N-1:2*N-H] == '0)
    else $error("top bits set"); // R5
  AST_RST_CLEAR: assert property (@(posedge clk_i)
    (OUT_REG && !rst_ni) |-> prod_o == '0) else $error("reset not clear"); // R7
endmodule

bind dcmul_top dcmul_chk #(.N(N), .OUT_REG(OUT_REG)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .prod_o(prod_o));

// File: tb/test_dcmul_top.sv
module test_dcmul_top;
  localparam int unsigned N = 8;

  logic           clk_i = 1'b0;
  logic           rst_ni;
  logic [N-1:0]   a_i, b_i;
  logic [2*N-1:0] prod_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  dcmul_top #(.N(N), .OUT_REG(1'b1)) i_dcmul_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .prod_o(prod_o));

  task automatic check(input string tag, input logic [2*N-1:0] act,
                       input logic [2*N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int x, input int y);
    if (x == 185 && y == 39) return "R8";
    if (x == 0 || y == 0) return "R2";
    if (x == 255 && y == 255) return "R3";
    if (x == 1 || y == 1) return "R4";
    if (x < 16 || y < 16) return "R5";
    return "R1";
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int pa, pb;
    bit have;
    rst_ni = 1'b0;
    a_i = '1;
    b_i = '1;
    #1 check("R7 reset state", prod_o, '0);
    @(posedge clk_i);
    #1 check("R7 reset held over edge", prod_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // exhaustive sweep: drive at negedge, check one cycle later
    have = 1'b0;
    pa = 0;
    pb = 0;
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        @(negedge clk_i);
        if (have) check(tag_of(pa, pb), prod_o, 16'(pa * pb));
        a_i = N'(x);
        b_i = N'(y);
        pa = x;
        pb = y;
        have = 1'b1;
      end
    end
    @(negedge clk_i);
    check("R3 all ones", prod_o, 16'hFE01);

    // R8 example directly
    a_i = 8'd185;
    b_i = 8'd39;
    @(negedge clk_i);
    check("R8 example", prod_o, 16'd7215);

    // R6 holds between edges
    a_i = 8'd3;
    b_i = 8'd5;
    #2 check("R6 hold before edge", prod_o, 16'd7215);
    a_i = 8'd200;
    #1 check("R6 hold on input change", prod_o, 16'd7215);
    a_i = 8'd3;
    @(negedge clk_i);
    check("R6 one cycle latency", prod_o, 16'd15);

    // R7 asynchronous clear mid-run
    a_i = 8'd7;
    b_i = 8'd9;
    @(negedge clk_i);
    check("R1 before reset", prod_o, 16'd63);
    rst_ni = 1'b0;
    #1 check("R7 async clear", prod_o, '0);
    @(negedge clk_i);
    check("R7 stays clear", prod_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", prod_o, 16'd63);

    finish_run();
  end
endmodule